// File: doc/BRIEF.md
# JTAG Master Bit-Shift Engine

This block is the host side of a JTAG link. Running from a system clock, it drives TCK, TMS and TDI toward a target's test access port (TAP) and samples the TDO line that comes back. A controller issues one command at a time through a start/busy/done handshake. The engine then produces the exact TCK pulse train and TMS pattern that the command needs, and in the done cycle it returns the word captured from TDO.

There are four operations. The first is a TAP reset that ends in Run-Test/Idle. Two more walk the TAP from Run-Test/Idle into Shift-IR or into Shift-DR. The fourth is a data shift of 1 to DATA_W bits. For each shift, the controller chooses the bit order, whether TMS rises together with the final bit, and whether the TAP is then walked back to Run-Test/Idle or parked in Update. A long scan can therefore be split across several chained shift commands. A scan can also be closed in Update, so the next selection passes straight to Select-DR without touching Run-Test/Idle.

TCK runs at the system clock divided by an even ratio. Each TCK level lasts a programmable number of system cycles. TCK rests low between commands.

Top module: `jtag_shift_engine`

## Requirements
- R1: Operation code 2'b01 (reset) issues five TCK pulses with TMS high, then one pulse with TMS low, and nothing else. The TAP finishes in Run-Test/Idle whatever its starting state.
- R2: Starting from Run-Test/Idle, code 2'b10 issues TMS 1,1,0,0 and leaves the TAP in Shift-IR. Code 2'b11 issues TMS 1,0,0 and leaves it in Shift-DR.
- R3: Code 2'b00 (shift) takes a count field holding the bit count minus one, so 0 means 1 bit. It issues exactly that many data pulses. When the order flag is 0, TDI carries data bit 0 first and continues upward. When the order flag is 1, TDI carries bit count-1 first and continues downward.
- R4: The TDO bits captured during a shift are reassembled in the same order that was used for sending. With order 0, the first captured bit lands in result bit 0. With order 1, it lands in result bit count-1. All result bits at or above the count read zero.
- R5: When the end flag is set, TMS is high on the last data pulse only. When the end flag is clear, TMS stays low on every data pulse and the TAP stays in the shift state, so the next shift continues the same scan.
- R6: After an ended shift with the idle flag set, the engine adds two pulses (TMS 1, then 0) and the TAP ends in Run-Test/Idle. With the idle flag clear, it adds one pulse (TMS 1) and the TAP ends in Update. When the end flag is clear, the idle flag is ignored.
- R7: TMS and TDI change only in the system cycle in which TCK falls, or while TCK is low between commands. They stay constant while TCK is high. TDO is sampled in the cycle in which TCK falls.
- R8: Each TCK high level and each TCK low level within a command lasts tckHalf system cycles, and a tckHalf of 0 acts as 1. TCK is low whenever busy is low.
- R9: A start is taken only while busy is low. A start raised while busy has no effect. done is high for exactly one cycle per command, and rdata is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Command request, taken when the engine is idle |
| cmdOp | input | 2 | 00 shift, 01 TAP reset, 10 to Shift-IR, 11 to Shift-DR |
| cmdData | input | DATA_W | Word to send on TDI |
| cmdLen | input | $clog2(DATA_W) | Bit count minus one |
| cmdMsbFirst | input | 1 | 1 sends the highest used bit first |
| cmdEnd | input | 1 | Raise TMS on the last data bit |
| cmdIdle | input | 1 | After an ended shift, return to Run-Test/Idle |
| tckHalf | input | DIV_W | System cycles per TCK level |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | DATA_W | Captured TDO word, valid with done |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data toward the target |
| tdo | input | 1 | Test data from the target |

## Verification
The bench builds the engine with DATA_W = 8 and DIV_W = 2. At that size a full sweep is practical: every bit count from 1 to 8, both bit orders, and all three ending modes, each run against several data patterns. The sweep also cycles through all four tckHalf codes, including the zero code, so every divide ratio is timed. A behavioural TAP model with a 64-bit capture register supplies known TDO streams. This lets the bench check chained IR transfers that split one scan across two commands with different bit orders.

// File: rtl/jse_pkg.sv
package jse_pkg;

  // Operation codes carried on cmdOp
  typedef enum logic [1:0] {
    OP_SHIFT = 2'b00,
    OP_RESET = 2'b01,
    OP_TO_IR = 2'b10,
    OP_TO_DR = 2'b11
  } jseOp_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // latch a new shift command
    logic step;   // one data pulse finished: advance TDI, capture TDO
  } jseStrb_t;

endpackage

// File: rtl/jse_ctrl.sv
module jse_ctrl
  import jse_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cmdOp,
  input  logic [CNT_W-1:0] cmdLen,
  input  logic             cmdEnd,
  input  logic             cmdIdle,
  input  logic [DIV_W-1:0] tckHalf,
  output logic             busy,
  output logic             done,
  output logic             tck,
  output logic             tms,
  output jseStrb_t         strb
);

  localparam int BL_W  = CNT_W + 1;
  localparam int SEQ_W = 6;

  typedef enum logic [1:0] {S_IDLE, S_SEQ, S_SHIFT, S_DONE} state_e;

  state_e           state;
  logic [DIV_W-1:0] halfReg, divCnt, halfM1;
  logic [BL_W-1:0]  bitLeft;
  logic [SEQ_W-1:0] tmsSeq;
  logic [2:0]       seqLeft;
  logic             tckR, tmsR, endReg, idleReg;
  logic             active, phaseEnd, pulseEnd, accept;

  always_comb begin
    halfM1    = (tckHalf == '0) ? '0 : tckHalf - DIV_W'(1);
    active    = (state == S_SEQ) || (state == S_SHIFT);
    phaseEnd  = active && (divCnt == '0);
    pulseEnd  = phaseEnd && tckR;
    accept    = (state == S_IDLE) && start;
    strb.load = accept && (cmdOp == OP_SHIFT);
    strb.step = pulseEnd && (state == S_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      halfReg <= '0;
      divCnt  <= '0;
      bitLeft <= '0;
      tmsSeq  <= '0;
      seqLeft <= '0;
      tckR    <= 1'b0;
      tmsR    <= 1'b0;
      endReg  <= 1'b0;
      idleReg <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          halfReg <= halfM1;
          divCnt  <= halfM1;
          tckR    <= 1'b0;
          endReg  <= cmdEnd;
          idleReg <= cmdIdle;
          case (cmdOp)
            OP_SHIFT: begin
              bitLeft <= {1'b0, cmdLen} + BL_W'(1);
              tmsR    <= (cmdLen == '0) && cmdEnd;
              state   <= S_SHIFT;
            end
            OP_RESET: begin
              tmsSeq  <= 6'b011111;
              seqLeft <= 3'd6;
              tmsR    <= 1'b1;
              state   <= S_SEQ;
            end
            OP_TO_IR: begin
              tmsSeq  <= 6'b000011;
              seqLeft <= 3'd4;
              tmsR    <= 1'b1;
              state   <= S_SEQ;
            end
            default: begin
              tmsSeq  <= 6'b000001;
              seqLeft <= 3'd3;
              tmsR    <= 1'b1;
              state   <= S_SEQ;
            end
          endcase
        end
        S_SEQ, S_SHIFT: begin
          if (phaseEnd) begin
            divCnt <= halfReg;
            tckR   <= ~tckR;
          end else begin
            divCnt <= divCnt - DIV_W'(1);
          end
          if (pulseEnd) begin
            if (state == S_SEQ) begin
              tmsSeq  <= tmsSeq >> 1;
              seqLeft <= seqLeft - 3'd1;
              if (seqLeft == 3'd1) state <= S_DONE;
              else                 tmsR  <= tmsSeq[1];
            end else if (bitLeft == BL_W'(1)) begin
              if (endReg) begin
                // tail: Exit1 -> Update (-> Run-Test/Idle)
                tmsSeq  <= 6'b000001;
                seqLeft <= idleReg ? 3'd2 : 3'd1;
                tmsR    <= 1'b1;
                state   <= S_SEQ;
              end else begin
                state <= S_DONE;
              end
            end else begin
              bitLeft <= bitLeft - BL_W'(1);
              tmsR    <= (bitLeft == BL_W'(2)) && endReg;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);
  assign tck  = tckR;
  assign tms  = tmsR;

  // R8
  tck_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R7
  tms_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    tck |-> $stable(tms));

  // R5
  tms_low_mid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SHIFT && bitLeft > BL_W'(1)) |-> !tms);

endmodule

// File: rtl/jse_datapath.sv
module jse_datapath
  import jse_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  jseStrb_t          strb,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [CNT_W-1:0]  cmdLen,
  input  logic              cmdMsbFirst,
  input  logic              tdo,
  output logic              tdi,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shReg, capReg, alignIn, revIn, revCap;
  logic [CNT_W-1:0]  lenReg, padIn, padReg;
  logic              msbReg;

  // Normalise both orders to "bit 0 goes out first"
  always_comb begin
    padIn   = TOP_IDX - cmdLen;
    padReg  = TOP_IDX - lenReg;
    alignIn = cmdData << padIn;
    for (int i = 0; i < DATA_W; i++) begin
      revIn[i]  = alignIn[DATA_W-1-i];
      revCap[i] = capReg[DATA_W-1-i];
    end
    rdata = msbReg ? revCap : (capReg >> padReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      capReg <= '0;
      lenReg <= '0;
      msbReg <= 1'b0;
    end else if (strb.load) begin
      shReg  <= cmdMsbFirst ? revIn : cmdData;
      capReg <= '0;
      lenReg <= cmdLen;
      msbReg <= cmdMsbFirst;
    end else if (strb.step) begin
      shReg  <= shReg >> 1;
      capReg <= {tdo, capReg[DATA_W-1:1]};
    end
  end

  assign tdi = shReg[0];

endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine
  import jse_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [1:0]                  cmdOp,
  input  logic [DATA_W-1:0]           cmdData,
  input  logic [$clog2(DATA_W)-1:0]   cmdLen,
  input  logic                        cmdMsbFirst,
  input  logic                        cmdEnd,
  input  logic                        cmdIdle,
  input  logic [DIV_W-1:0]            tckHalf,
  output logic                        busy,
  output logic                        done,
  output logic [DATA_W-1:0]           rdata,
  output logic                        tck,
  output logic                        tms,
  output logic                        tdi,
  input  logic                        tdo
);

  localparam int CNT_W = $clog2(DATA_W);

  jseStrb_t strb;

  jse_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdOp(cmdOp), .cmdLen(cmdLen),
    .cmdEnd(cmdEnd), .cmdIdle(cmdIdle), .tckHalf(tckHalf),
    .busy(busy), .done(done), .tck(tck), .tms(tms), .strb(strb)
  );

  jse_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdData(cmdData), .cmdLen(cmdLen),
    .cmdMsbFirst(cmdMsbFirst), .tdo(tdo), .tdi(tdi), .rdata(rdata)
  );

  // R7
  tdi_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    tck |-> $stable(tdi));

endmodule

// File: tb/tb_jtag_shift_engine.sv
`timescale 1ns/1ps
module tb_jtag_shift_engine;

  localparam int TW = 8;
  localparam int TD = 2;
  localparam int CW = $clog2(TW);

  typedef enum int {TLR, RTI, SDS, CDR, SDR, E1D, PDR, E2D, UDR,
                    SIS, CIR, SIR, E1I, PIR, E2I, UIR} tap_e;

  logic clk = 0, rstN = 0, start = 0;
  logic [1:0] cmdOp = '0;
  logic [TW-1:0] cmdData = '0;
  logic [CW-1:0] cmdLen = '0;
  logic cmdMsbFirst = 0, cmdEnd = 0, cmdIdle = 0;
  logic [TD-1:0] tckHalf = '0;
  logic busy, done, tck, tms, tdi;
  logic tdo = 0;
  logic [TW-1:0] rdata;

  jtag_shift_engine #(.DATA_W(TW), .DIV_W(TD)) dut (
    .clk(clk), .rstN(rstN), .start(start), .cmdOp(cmdOp), .cmdData(cmdData),
    .cmdLen(cmdLen), .cmdMsbFirst(cmdMsbFirst), .cmdEnd(cmdEnd), .cmdIdle(cmdIdle),
    .tckHalf(tckHalf), .busy(busy), .done(done), .rdata(rdata),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;

  // ---------------- behavioural TAP ----------------
  tap_e tapSt = SIR;
  logic [63:0] dr = '0, capVal = '0;
  logic tmsHist [64];
  logic tdiHist [64];
  int pulseCnt = 0, tdiCnt = 0;

  function automatic tap_e nextSt(tap_e s, logic m);
    case (s)
      TLR: return m ? TLR : RTI;
      RTI: return m ? SDS : RTI;
      SDS: return m ? SIS : CDR;
      CDR: return m ? E1D : SDR;
      SDR: return m ? E1D : SDR;
      E1D: return m ? UDR : PDR;
      PDR: return m ? E2D : PDR;
      E2D: return m ? UDR : SDR;
      UDR: return m ? SDS : RTI;
      SIS: return m ? TLR : CIR;
      CIR: return m ? E1I : SIR;
      SIR: return m ? E1I : SIR;
      E1I: return m ? UIR : PIR;
      PIR: return m ? E2I : PIR;
      E2I: return m ? UIR : SIR;
      default: return m ? SDS : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    if (pulseCnt < 64) tmsHist[pulseCnt] = tms;
    pulseCnt++;
    if (tapSt == CDR || tapSt == CIR) dr = capVal;
    else if (tapSt == SDR || tapSt == SIR) begin
      if (tdiCnt < 64) tdiHist[tdiCnt] = tdi;
      tdiCnt++;
      dr = {tdi, dr[63:1]};
    end
    tapSt = nextSt(tapSt, tms);
  end

  always @(negedge tck) tdo <= dr[0];

  // ---------------- TCK level timing monitor ----------------
  int expHalf = 1, highRun = 0, periodErr = 0;
  always @(negedge clk) begin
    if (tck) highRun++;
    else if (highRun != 0) begin
      if (highRun != expHalf) periodErr++;
      highRun = 0;
    end
  end

  // ---------------- watchdog ----------------
  always @(negedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] ordered(logic [63:0] v, int off, int n, bit msb);
    logic [TW-1:0] r = '0;
    for (int i = 0; i < n; i++) begin
      if (msb) r[n-1-i] = v[off+i];
      else     r[i]     = v[off+i];
    end
    return r;
  endfunction

  function automatic logic [TW-1:0] sentWord(int n);
    logic [TW-1:0] r = '0;
    for (int i = 0; i < n && i < TW; i++) r[i] = tdiHist[i];
    return r;
  endfunction

  function automatic logic [63:0] tmsWord(int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n && i < 64; i++) r[i] = tmsHist[i];
    return r;
  endfunction

  task automatic runCmd(input logic [1:0] op, input logic [TW-1:0] d, input int n,
                        input bit msb, input bit en, input bit idl, input int half,
                        output logic [TW-1:0] res);
    int guard;
    @(negedge clk);
    pulseCnt = 0; tdiCnt = 0;
    expHalf = (half == 0) ? 1 : half;
    start = 1; cmdOp = op; cmdData = d; cmdLen = CW'(n - 1);
    cmdMsbFirst = msb; cmdEnd = en; cmdIdle = idl; tckHalf = TD'(half);
    @(negedge clk);
    start = 0;
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    if (!done) chk("R9 timeout", 64'(done), 64'd1);
    res = rdata;
    @(negedge clk);
    chk("R9 done one cycle", 64'(done), 64'd0);
  endtask

  logic [TW-1:0] res, res2, pat;
  int iter, tail, pe0;
  bit en, idl;

  initial begin
    repeat (4) @(negedge clk);
    // R8 R9: reset state
    chk("R9 busy after reset", 64'(busy), 64'd0);
    chk("R9 done after reset", 64'(done), 64'd0);
    chk("R8 tck low after reset", 64'(tck), 64'd0);
    rstN = 1;
    @(negedge clk);

    // R1: reset from assorted TAP states, every half period code
    for (int h = 0; h < 4; h++) begin
      tapSt = tap_e'(h * 4 + 3);
      pe0 = periodErr;
      runCmd(2'b01, '0, 1, 0, 0, 0, h, res);
      chk("R1 end state", 64'(tapSt), 64'(RTI));
      chk("R1 pulse count", 64'(pulseCnt), 64'd6);
      chk("R1 tms pattern", tmsWord(6), 64'h1F);
      chk("R8 tck half period", 64'(periodErr - pe0), 64'd0);
      chk("R8 tck idle low", 64'(tck), 64'd0);
    end

    // R2..R6, R8: sweep over counts, orders, tails and patterns
    iter = 0;
    for (int n = 1; n <= TW; n++)
      for (int msb = 0; msb < 2; msb++)
        for (int p = 0; p < 3; p++)
          for (int mode = 0; mode < 3; mode++) begin
            pat = (p == 0) ? 8'hA5 : (p == 1) ? 8'h3C : TW'(iter * 37 + 11);
            en  = (mode != 2);
            idl = (mode != 1);
            tail = (mode == 0) ? 2 : (mode == 1) ? 1 : 0;
            if (tapSt != RTI) runCmd(2'b01, '0, 1, 0, 0, 0, iter % 4, res);
            capVal = 64'h9E3779B97F4A7C15 * 64'(iter + 1);
            runCmd(2'b11, '0, 1, 0, 0, 0, iter % 4, res);
            chk("R2 to Shift-DR", 64'(tapSt), 64'(SDR));
            pe0 = periodErr;
            runCmd(2'b00, pat, n, msb[0], en, idl, iter % 4, res);
            chk("R3 data pulses", 64'(tdiCnt), 64'(n));
            chk("R3 tdi order", 64'(sentWord(n)), 64'(ordered(64'(pat), 0, n, msb[0])));
            chk("R4 tdo reassembly", 64'(res), 64'(ordered(capVal, 0, n, msb[0])));
            chk("R5 tms on shift",
                tmsWord(n + tail),
                (64'(en) << (n - 1)) | (tail != 0 ? (64'd1 << n) : 64'd0));
            chk("R6 end state", 64'(tapSt),
                64'((mode == 0) ? RTI : (mode == 1) ? UDR : SDR));
            chk("R8 tck half period", 64'(periodErr - pe0), 64'd0);
            iter++;
          end

    // R2 R4 R5 R6: chained IR scan split into two commands, mixed order
    runCmd(2'b01, '0, 1, 0, 0, 0, 1, res);
    capVal = 64'hD1B54A32D192ED03;
    runCmd(2'b10, '0, 1, 0, 0, 0, 1, res);
    chk("R2 to Shift-IR", 64'(tapSt), 64'(SIR));
    chk("R2 tms to IR", tmsWord(4), 64'h3);
    runCmd(2'b00, 8'h16, 5, 0, 0, 1, 2, res);
    chk("R5 chained stays in shift", 64'(tapSt), 64'(SIR));
    chk("R4 chained part one", 64'(res), 64'(ordered(capVal, 0, 5, 0)));
    runCmd(2'b00, 8'h05, 3, 1, 1, 1, 2, res2);
    chk("R3 chained part two tdi", 64'(sentWord(3)), 64'(ordered(64'h05, 0, 3, 1)));
    chk("R4 chained part two", 64'(res2), 64'(ordered(capVal, 5, 3, 1)));
    chk("R6 chained end state", 64'(tapSt), 64'(RTI));

    // R9: a start raised while busy is ignored
    capVal = 64'h0123456789ABCDEF;
    runCmd(2'b11, '0, 1, 0, 0, 0, 3, res);
    @(negedge clk);
    pulseCnt = 0; tdiCnt = 0; expHalf = 3;
    start = 1; cmdOp = 2'b00; cmdData = 8'hC6; cmdLen = CW'(7);
    cmdMsbFirst = 1; cmdEnd = 1; cmdIdle = 1; tckHalf = TD'(3);
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    start = 1; cmdOp = 2'b01; cmdData = 8'h3B; cmdMsbFirst = 0;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    chk("R9 busy start ignored result", 64'(rdata), 64'(ordered(capVal, 0, 8, 1)));
    chk("R9 busy start ignored tdi", 64'(sentWord(8)), 64'(ordered(64'hC6, 0, 8, 1)));
    repeat (30) @(negedge clk);
    chk("R9 no second command", 64'(pulseCnt), 64'd10);
    chk("R9 idle after", 64'(busy), 64'd0);
    chk("R6 final state", 64'(tapSt), 64'(RTI));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule